// File: doc/BRIEF.md
# Continuous-Read Sigma-Delta ADC Host

This block is the host side of the serial link to a sigma-delta converter that has been put into continuous-read mode. A start command asserts chip select and shifts the 8-bit enter instruction 0x5C out on the serial data line, most significant bit first. The converter then pushes each result out by itself. The host sends no command per sample. It watches the combined data-out/ready line, and each falling edge of that line starts a read. The read clocks in a 24-bit conversion word, followed by a trailing status byte when status-append was selected. The sample goes out on a valid/ready stream.

A stop command makes the host leave continuous-read mode. It sends the exit instruction 0x58, and it may do so only right after the ready line has gone low. A stop that arrives at any other time is held until the next ready-low edge. That conversion is then not read. Outside the two instruction bytes the host data line stays low.

Output stream rules: a sample is held on `smp_data_o`/`smp_chan_o` with `smp_valid_o` high until a cycle where `smp_ready_i` is high. Each conversion can be read only once, so the converter cannot be stalled. If a new sample completes while the previous one is still unaccepted, the new sample replaces it and `smp_drop_o` pulses.

Top module: `cread_host`

## Requirements
- R1: While reset is held and in the cycle after it, `sclk_o` is high, `mosi_o` is low, `cs_n_o` is high, and `smp_valid_o` and `active_o` are low.
- R2: A `start_i` pulse while idle drives `cs_n_o` low and shifts out 0x5C in 8 SCLK cycles, most significant bit first. `mosi_o` changes only when `sclk_o` falls and is stable while it is high, so it is sampled on the rising edge. `active_o` is then high.
- R3: While active and not sending an instruction, `mosi_o` stays low. The host therefore never drives more than 8 consecutive ones, far below the 40-ones reset run.
- R4: In active mode, each falling edge of `miso_rdy_i` starts a read. The read is 24 SCLK cycles, or 32 when `status_en_i` was high at start, and it transfers bits most significant first.
- R5: The 24 bits read first become `smp_data_o`. With status-append, `smp_chan_o` is bits 3..0 of the status byte (the last 4 bits shifted in); without it, `smp_chan_o` is 0.
- R6: `smp_valid_o` stays high with stable data until accepted. A sample completing while the previous one is unaccepted overwrites it and pulses `smp_drop_o` for one cycle.
- R7: A `stop_i` pulse while active is held pending. Right after the next ready-low edge, the host sends 0x58 (8 SCLK cycles) instead of reading. No sample is produced for that conversion. Afterwards `cs_n_o` is high and `active_o` is low.
- R8: `stop_i` while idle and `start_i` while active have no effect: no SCLK edge, and no change of `active_o`.
- R9: If `miso_rdy_i` is still low at the end of a read frame, `smp_overrun_o` pulses for one cycle, together with the sample's push. No new read starts until the line has gone high and then low again.
- R10: Each SCLK half period lasts `DIV_HALF` clock cycles, and SCLK idles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse: enter continuous-read mode |
| stop_i | input | 1 | Pulse: leave continuous-read mode |
| status_en_i | input | 1 | Read a trailing status byte per sample (taken at start) |
| sclk_o | output | 1 | Serial clock to converter, idle high |
| cs_n_o | output | 1 | Chip select, low while active |
| mosi_o | output | 1 | Serial data to converter |
| miso_rdy_i | input | 1 | Combined data-out / ready line from converter |
| smp_valid_o | output | 1 | Sample valid |
| smp_ready_i | input | 1 | Sample accepted by sink |
| smp_data_o | output | 24 | Conversion word |
| smp_chan_o | output | 4 | Channel from status byte |
| smp_drop_o | output | 1 | One-cycle pulse: unaccepted sample overwritten |
| smp_overrun_o | output | 1 | One-cycle pulse: ready still low at frame end |
| active_o | output | 1 | Continuous-read mode in effect |

## Verification
The bench puts a converter model on the serial pins. The model drives result bits on falling SCLK and logs every rising-edge bit of `mosi_o`. A host that sent a command per sample, or that let data bits leak onto `mosi_o`, would change the edge count or the ones count seen by the model. A stop issued while the ready line is high must not cause any SCLK activity until the next ready-low edge; a host that sent 0x58 at once would break the exit timing rule. The bench also holds the sink off across two conversions, which must produce one drop and leave the newer word on the output. It leaves the ready line low after a frame, which must raise an overrun and must not start a second read of the same conversion.

// File: rtl/cread_pkg.sv
package cread_pkg;
  parameter int WORD_W = 24;
  parameter int STAT_W = 8;
  parameter int CH_W   = 4;
  parameter int OP_W   = 8;
  localparam int FRAME_W = WORD_W + STAT_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  localparam logic [OP_W-1:0] OP_ENTER = 8'h5C;
  localparam logic [OP_W-1:0] OP_LEAVE = 8'h58;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ENTER, ST_WAIT, ST_READ, ST_LEAVE
  } host_st_t;
endpackage

// File: rtl/cread_bitengine.sv
module cread_bitengine
  import cread_pkg::*;
#(
  parameter int HALF = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [CNT_W-1:0]   nbits,
  input  logic [OP_W-1:0]    txb,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic [FRAME_W-1:0] rx,
  output logic               done
);
  localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic            busy;
  logic [HC_W-1:0] hc;
  logic [CNT_W-1:0] left;
  logic [OP_W-1:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      hc   <= '0;
      left <= '0;
      tx_q <= '0;
      sclk <= 1'b1;
      mosi <= 1'b0;
      rx   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy <= 1'b1;
          hc   <= '0;
          left <= nbits;
          sclk <= 1'b0;
          mosi <= txb[OP_W-1];
          tx_q <= {txb[OP_W-2:0], 1'b0};
          rx   <= '0;
        end
      end else if (hc == HC_W'(HALF - 1)) begin
        hc <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[FRAME_W-2:0], miso};
          left <= left - 1'b1;
        end else if (left == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          mosi <= 1'b0;
        end else begin
          sclk <= 1'b0;
          mosi <= tx_q[OP_W-1];
          tx_q <= {tx_q[OP_W-2:0], 1'b0};
        end
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end

  initial begin
    half_min_chk: assert (HALF >= 3);
  end

  // R2
  mosi_stable_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk) && busy) |-> $stable(mosi));

  // R10
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> sclk);
endmodule

// File: rtl/cread_outreg.sv
module cread_outreg
  import cread_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] pdata,
  input  logic [CH_W-1:0]   pchan,
  output logic              valid,
  input  logic              ready,
  output logic [WORD_W-1:0] data,
  output logic [CH_W-1:0]   chan,
  output logic              drop
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      chan  <= '0;
      drop  <= 1'b0;
    end else begin
      drop <= push && valid && !ready;
      if (push) begin
        valid <= 1'b1;
        data  <= pdata;
        chan  <= pchan;
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
    end
  end

  // R6
  hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !push) |=> (valid && $stable(data) && $stable(chan)));
endmodule

// File: rtl/cread_host.sv
module cread_host
  import cread_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              status_en_i,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_rdy_i,
  output logic              smp_valid_o,
  input  logic              smp_ready_i,
  output logic [WORD_W-1:0] smp_data_o,
  output logic [CH_W-1:0]   smp_chan_o,
  output logic              smp_drop_o,
  output logic              smp_overrun_o,
  output logic              active_o
);
  host_st_t st;
  logic go_q;
  logic [CNT_W-1:0] go_nb;
  logic [OP_W-1:0]  go_op;
  logic stat_q, stop_pend;
  logic rdy_s1, rdy_s2, rdy_q, rdy_fall;
  logic eng_done;
  logic [FRAME_W-1:0] rx;
  logic push_q, ovr_q;
  logic [WORD_W-1:0] pdata;
  logic [CH_W-1:0]   pchan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_s1 <= 1'b1;
      rdy_s2 <= 1'b1;
      rdy_q  <= 1'b1;
    end else begin
      rdy_s1 <= miso_rdy_i;
      rdy_s2 <= rdy_s1;
      rdy_q  <= rdy_s2;
    end
  end
  assign rdy_fall = rdy_q && !rdy_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      go_q      <= 1'b0;
      go_nb     <= '0;
      go_op     <= '0;
      stat_q    <= 1'b0;
      stop_pend <= 1'b0;
      push_q    <= 1'b0;
      ovr_q     <= 1'b0;
      pdata     <= '0;
      pchan     <= '0;
    end else begin
      go_q   <= 1'b0;
      push_q <= 1'b0;
      ovr_q  <= 1'b0;
      if (stop_i && st != ST_IDLE) stop_pend <= 1'b1;
      unique case (st)
        ST_IDLE: begin
          stop_pend <= 1'b0;
          if (start_i) begin
            stat_q <= status_en_i;
            go_q   <= 1'b1;
            go_op  <= OP_ENTER;
            go_nb  <= CNT_W'(OP_W);
            st     <= ST_ENTER;
          end
        end
        ST_ENTER: if (eng_done) st <= ST_WAIT;
        ST_WAIT: begin
          if (rdy_fall) begin
            go_q <= 1'b1;
            if (stop_pend || stop_i) begin
              stop_pend <= 1'b0;
              go_op     <= OP_LEAVE;
              go_nb     <= CNT_W'(OP_W);
              st        <= ST_LEAVE;
            end else begin
              go_op <= '0;
              go_nb <= stat_q ? CNT_W'(FRAME_W) : CNT_W'(WORD_W);
              st    <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (eng_done) begin
            push_q <= 1'b1;
            ovr_q  <= !rdy_s2;
            pdata  <= stat_q ? rx[FRAME_W-1:STAT_W] : rx[WORD_W-1:0];
            pchan  <= stat_q ? rx[CH_W-1:0] : '0;
            st     <= ST_WAIT;
          end
        end
        ST_LEAVE: if (eng_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  cread_bitengine #(.HALF(DIV_HALF)) eng_i (
    .clk(clk), .rst_n(rst_n), .go(go_q), .nbits(go_nb), .txb(go_op),
    .miso(miso_rdy_i), .sclk(sclk_o), .mosi(mosi_o), .rx(rx), .done(eng_done)
  );

  cread_outreg out_i (
    .clk(clk), .rst_n(rst_n), .push(push_q), .pdata(pdata), .pchan(pchan),
    .valid(smp_valid_o), .ready(smp_ready_i), .data(smp_data_o),
    .chan(smp_chan_o), .drop(smp_drop_o)
  );

  assign cs_n_o        = (st == ST_IDLE);
  assign active_o      = (st != ST_IDLE);
  assign smp_overrun_o = ovr_q;

  // R3
  din_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT || st == ST_READ) |-> !mosi_o);

  // R10
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  // R9
  ovr_with_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_overrun_o |=> smp_valid_o);

  // R7
  leave_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && go_q == 1'b0 && $past(st) == ST_WAIT && rdy_fall && stop_pend)
      |=> (st == ST_LEAVE && !rdy_s1 || st == ST_LEAVE));
endmodule

// File: tb/cread_host_tb.sv
module cread_host_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h123456_05, 32'hFFFFFF_0F, 32'h000000_A0,
    32'h800001_93, 32'h5A5A5A_6C, 32'h7FFFFE_F7
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, status_en_i = 1'b0, smp_ready_i = 1'b1;
  logic sdo = 1'b1;
  logic sclk_o, cs_n_o, mosi_o, smp_valid_o, smp_drop_o, smp_overrun_o, active_o;
  logic [23:0] smp_data_o;
  logic [3:0]  smp_chan_o;

  int total = 0, bad = 0;
  int edges = 0, ones = 0, run = 0, maxrun = 0;
  logic [7:0] mlog = '0;
  logic [31:0] mframe = '0;
  int mleft = 0;
  bit marm = 0, mkeep = 0;
  int nsmp = 0, ndrop = 0, novr = 0;
  logic [23:0] ldata = '0;
  logic [3:0]  lchan = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cread_host #(.DIV_HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .status_en_i(status_en_i), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
    .mosi_o(mosi_o), .miso_rdy_i(sdo), .smp_valid_o(smp_valid_o),
    .smp_ready_i(smp_ready_i), .smp_data_o(smp_data_o),
    .smp_chan_o(smp_chan_o), .smp_drop_o(smp_drop_o),
    .smp_overrun_o(smp_overrun_o), .active_o(active_o)
  );

  always @(negedge sclk_o)
    if (rst_n && marm && mleft > 0) sdo <= mframe[mleft-1];

  always @(posedge sclk_o) begin
    if (rst_n) begin
      edges++;
      mlog <= {mlog[6:0], mosi_o};
      if (mosi_o) begin ones++; run++; if (run > maxrun) maxrun = run; end
      else run = 0;
      if (marm && mleft > 0) begin
        mleft--;
        if (mleft == 0) begin marm = 0; sdo <= mkeep ? 1'b0 : 1'b1; end
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (smp_valid_o && smp_ready_i) begin nsmp++; ldata <= smp_data_o; lchan <= smp_chan_o; end
      if (smp_drop_o) ndrop++;
      if (smp_overrun_o) novr++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic conv(input logic [31:0] w, input int nb, input bit keep, input bit waitend);
    @(negedge clk);
    mframe = w; mleft = nb; mkeep = keep; marm = 1; sdo = 1'b0;
    if (waitend) begin
      while (marm) @(negedge clk);
      repeat (12) @(negedge clk);
    end
  endtask

  task automatic measure_low(output int n);
    @(negedge sclk_o);
    n = 0;
    do begin @(negedge clk); n++; end while (!sclk_o);
    n = n - 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e0, o0, n0, lowlen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sclk_o && !mosi_o && cs_n_o && !smp_valid_o && !active_o, "R1",
        {27'b0, sclk_o, mosi_o, cs_n_o, smp_valid_o, active_o}, 32'h14);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk_o && cs_n_o && !active_o, "R1", {29'b0, sclk_o, cs_n_o, active_o}, 32'h6);

    // R2 enter with status append
    status_en_i = 1'b1;
    pulse(start_i);
    chk(!cs_n_o, "R2", {31'b0, cs_n_o}, 0);
    repeat (80) @(negedge clk);
    chk(edges == 8 && mlog == 8'h5C && active_o, "R2", {edges[7:0], mlog, 15'b0, active_o}, {8'd8, 8'h5C, 16'h1});

    // R4 R5 vector table walk
    for (int i = 0; i < NVEC; i++) begin
      e0 = edges; o0 = ones; n0 = nsmp;
      conv(VEC[i], 32, 0, 1);
      chk(edges - e0 == 32, "R4", edges - e0, 32);
      chk(ones == o0, "R3", ones, o0);
      chk(nsmp == n0 + 1 && ldata == VEC[i][31:8], "R5", {8'b0, ldata}, {8'b0, VEC[i][31:8]});
      chk(lchan == VEC[i][3:0], "R5", lchan, VEC[i][3:0]);
    end

    // R6 back-pressure and drop
    smp_ready_i = 1'b0;
    n0 = nsmp;
    conv(32'hAAAAAA_01, 32, 0, 1);
    repeat (30) @(negedge clk);
    chk(smp_valid_o && smp_data_o == 24'hAAAAAA, "R6", {8'b0, smp_data_o}, 32'hAAAAAA);
    conv(32'hBBBBBB_02, 32, 0, 1);
    chk(ndrop == 1 && smp_data_o == 24'hBBBBBB && smp_chan_o == 4'h2, "R6", {4'b0, smp_chan_o, smp_data_o}, 32'h02BBBBBB);
    @(negedge clk); smp_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(nsmp == n0 + 1 && !smp_valid_o, "R6", nsmp - n0, 1);

    // R8 start while active ignored
    e0 = edges;
    pulse(start_i);
    repeat (60) @(negedge clk);
    chk(edges == e0 && active_o, "R8", edges - e0, 0);

    // R9 overrun: line stays low after frame
    e0 = edges; n0 = nsmp;
    conv(32'h0F0F0F_03, 32, 1, 1);
    chk(novr == 1 && nsmp == n0 + 1, "R9", novr, 1);
    repeat (60) @(negedge clk);
    chk(edges - e0 == 32, "R9", edges - e0, 32);
    sdo = 1'b1;
    repeat (10) @(negedge clk);
    conv(32'h314159_04, 32, 0, 1);
    chk(ldata == 24'h314159 && novr == 1, "R9", {8'b0, ldata}, 32'h314159);

    // R7 stop held pending, then exit after ready low
    e0 = edges; n0 = nsmp;
    pulse(stop_i);
    repeat (60) @(negedge clk);
    chk(edges == e0 && active_o, "R7", edges - e0, 0);
    conv(32'hFFFFFF_FF, 32, 0, 0);
    repeat (120) @(negedge clk);
    chk(edges - e0 == 8 && mlog == 8'h58, "R7", {edges[15:0] - e0[15:0], 8'b0, mlog}, 32'h00080058);
    chk(!active_o && cs_n_o && nsmp == n0, "R7", {30'b0, active_o, cs_n_o}, 32'h1);
    marm = 0; sdo = 1'b1;
    chk(maxrun <= 8, "R3", maxrun, 8);

    // R8 stop while idle ignored
    repeat (10) @(negedge clk);
    e0 = edges;
    pulse(stop_i);
    repeat (40) @(negedge clk);
    chk(edges == e0 && !active_o, "R8", edges - e0, 0);

    // no status append session, R10 half period
    status_en_i = 1'b0;
    pulse(start_i);
    repeat (80) @(negedge clk);
    e0 = edges;
    fork
      conv(32'h00ABCDEF, 24, 0, 1);
      measure_low(lowlen);
    join
    chk(lowlen == HALF, "R10", lowlen, HALF);
    chk(edges - e0 == 24, "R4", edges - e0, 24);
    chk(ldata == 24'hABCDEF && lchan == 4'h0, "R5", {4'b0, lchan, ldata}, 32'h00ABCDEF);

    pulse(stop_i);
    conv(32'h0, 24, 0, 0);
    repeat (120) @(negedge clk);
    chk(!active_o && mlog == 8'h58, "R7", mlog, 8'h58);
    marm = 0; sdo = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule